// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider Controller

This block divides a fast synthesized clock by a fractional ratio N + M and produces the feedback pulse that a phase-locked loop compares with its reference. Within any single output period it divides by a whole number, either N or N + 1. A 16-bit fractional accumulator advances once per output period and chooses which of the two applies. Over many periods the fraction of periods that take the longer modulus equals M, so the average ratio is N + M. For example, N = 10 with M close to 0.3 gives an average close to 10.3.

The divide uses a swallow-counter arrangement. A main counter runs through N input cycles. When the modulus select is set, one extra swallow cycle follows before the terminal pulse. The accumulator residue is a port of the block, so an external phase-error compensator can cancel the periodic phase error that the modulus switching creates. The phase detector, the loop filter and the oscillator sit outside this block.

Top module: `fracn_divider`

## Requirements
- R1: A synchronous reset clears the residue and the modulus select to 0 and samples `div_n`. The first feedback pulse then appears in the N-th input cycle after reset.
- R2: At the end of each output period, the residue becomes (residue + `frac_m`) mod 2^16. Here `frac_m` is read as an unsigned fraction of value `frac_m`/2^16.
- R3: At the end of each output period, the modulus select becomes the carry out of that 16-bit addition. It is 1 exactly when residue + `frac_m` ≥ 2^16.
- R4: An output period lasts N input cycles while the modulus select is 0, and N + 1 input cycles while it is 1.
- R5: `fb_pulse` is high for exactly one input cycle, the last cycle of each output period.
- R6: The modulus select and the residue do not change inside an output period. They change only on the edge that ends a period.
- R7: Over P consecutive periods after reset, the total number of input cycles is P·N + floor((P−1)·M/2^16). This makes the average ratio N + M.
- R8: When `frac_m` is 0, the modulus select never asserts and every period lasts exactly N cycles.
- R9: `div_n` (valid range 2 to 2^8−1) is sampled at reset and at the end of each period. A change in the middle of a period first affects the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed synthesized clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| div_n | input | 8 | Integer part N of the ratio, at least 2 |
| frac_m | input | 16 | Fractional part M as an unsigned value over 2^16 |
| fb_pulse | output | 1 | One-cycle feedback pulse at the end of each output period |
| mod_sel | output | 1 | Current modulus select: 0 divides by N, 1 by N+1 |
| residue | output | 16 | Accumulator state, used by phase-error compensation |

## Verification
The assertions check four things on every cycle:
- the length of each period, measured by the checker's own cycle counter against the sampled N and the select;
- that the select and the residue stay constant inside a period;
- the carry-and-residue update across each period boundary;
- the cleared state after reset.

The long-run average ratio depends on many periods together, so only the bench's sweeps can show it. The bench covers a grid of N and M values, including N = 2, N = 255, M = 0 and M near 1. It also runs a scenario that changes N in the middle of a period, which shows that the new value waits for the next period.

// File: rtl/fracn_divider.sv
module fracn_divider #(
  parameter int NW = 8,
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] div_n,
  input  logic [KW-1:0] frac_m,
  output logic          fb_pulse,
  output logic          mod_sel,
  output logic [KW-1:0] residue
);

  logic [NW-1:0] n_q;
  logic [NW-1:0] cnt;
  logic          in_sw;
  logic          main_end;
  logic [KW:0]   sum;

  assign main_end = (cnt == n_q - 1'b1);
  assign fb_pulse = mod_sel ? in_sw : main_end;
  assign sum      = {1'b0, residue} + {1'b0, frac_m};

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q     <= div_n;
      cnt     <= '0;
      in_sw   <= 1'b0;
      mod_sel <= 1'b0;
      residue <= '0;
    end else if (fb_pulse) begin
      n_q     <= div_n;
      cnt     <= '0;
      in_sw   <= 1'b0;
      mod_sel <= sum[KW];
      residue <= sum[KW-1:0];
    end else if (main_end) begin
      in_sw   <= 1'b1;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end

endmodule

module fracn_divider_chk #(
  parameter int NW = 8,
  parameter int KW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [NW-1:0] div_n,
  input logic [KW-1:0] frac_m,
  input logic          fb_pulse,
  input logic          mod_sel,
  input logic [KW-1:0] residue
);

  logic [NW:0]   len;
  logic [NW-1:0] n_seen;

  always_ff @(posedge clk) begin
    if (rst || fb_pulse) begin
      len    <= {{NW{1'b0}}, 1'b1};
      n_seen <= div_n;
    end else begin
      len    <= len + 1'b1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (residue == '0 && !mod_sel)); // R1
  AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |-> (len == {1'b0, n_seen} + mod_sel)); // R4
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> ({mod_sel, residue} == $past({1'b0, residue} + {1'b0, frac_m}))); // R2
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fb_pulse |=> $stable(mod_sel)); // R6
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fb_pulse |=> $stable(residue)); // R6
  AST_ZERO_FRAC: assert property (@(posedge clk) disable iff (rst)
    (fb_pulse && frac_m == '0 && !mod_sel) |=> !mod_sel); // R8
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse); // R5

endmodule

bind fracn_divider fracn_divider_chk #(.NW(NW), .KW(KW)) chk_i (
  .clk(clk), .rst(rst), .div_n(div_n), .frac_m(frac_m),
  .fb_pulse(fb_pulse), .mod_sel(mod_sel), .residue(residue)
);

// File: tb/fracn_divider_tb_top.sv
module fracn_divider_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  div_n = 8'd10;
  logic [15:0] frac_m = 16'd0;
  logic        fb_pulse, mod_sel;
  logic [15:0] residue;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] eacc;
  logic        esel;

  always #5 clk = ~clk;

  fracn_divider dut_i (
    .clk(clk), .rst(rst), .div_n(div_n), .frac_m(frac_m),
    .fb_pulse(fb_pulse), .mod_sel(mod_sel), .residue(residue)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    eacc = '0;
    esel = 1'b0;
    chk(residue == 16'd0, "R1 residue", residue, 0);
    chk(mod_sel == 1'b0, "R1 mod_sel", mod_sel, 0);
  endtask

  // Measures one period starting at the current negedge, then steps into the next period.
  task automatic run_period(input int n_exp, output int len);
    int bad_sel;
    int bad_res;
    logic [16:0] s;
    len = 1;
    bad_sel = 0;
    bad_res = 0;
    while (!fb_pulse && len < 600) begin
      if (mod_sel !== esel) bad_sel++;
      if (residue !== eacc) bad_res++;
      @(negedge clk);
      len++;
    end
    chk(bad_sel == 0 && bad_res == 0, "R6 hold within period", bad_sel + bad_res, 0);
    chk(len == n_exp + esel, "R4 period length", len, n_exp + esel);
    @(negedge clk);
    chk(fb_pulse == 1'b0, "R5 pulse width", fb_pulse, 0);
    s = {1'b0, eacc} + {1'b0, frac_m};
    esel = s[16];
    eacc = s[15:0];
    chk(residue == eacc, "R2 residue update", residue, eacc);
    chk(mod_sel == esel, "R3 carry", mod_sel, esel);
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int nlist [5] = '{2, 3, 7, 10, 255};
    int mlist [5] = '{0, 16'h4CCD, 16'h8000, 16'hC000, 16'hFFFF};
    int len;
    int total;
    int sel_seen;
    longint expt;
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        div_n  = nlist[i][7:0];
        frac_m = mlist[j][15:0];
        do_reset();
        total = 0;
        sel_seen = 0;
        for (int p = 0; p < 40; p++) begin
          run_period(nlist[i], len);
          total += len;
          if (mod_sel) sel_seen++;
        end
        expt = 40 * nlist[i] + (39 * longint'(mlist[j])) / 65536;
        chk(total == expt, "R7 average ratio", total, expt);
        if (mlist[j] == 0)
          chk(sel_seen == 0 && total == 40 * nlist[i], "R8 zero fraction", total, 40 * nlist[i]);
      end
    end

    div_n  = 8'd5;
    frac_m = 16'h8000;
    do_reset();
    @(negedge clk);
    div_n = 8'd9;
    begin
      int l2;
      l2 = 2;
      while (!fb_pulse && l2 < 600) begin
        @(negedge clk);
        l2++;
      end
      chk(l2 == 5, "R9 old N kept mid-period", l2, 5);
      @(negedge clk);
      eacc = 16'h8000;
      esel = 1'b0;
    end
    run_period(9, len);
    chk(len == 9, "R9 new N next period", len, 9);
    run_period(9, len);
    chk(len == 10, "R9 new N with swallow", len, 10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule